// File: doc/BRIEF.md
# Wired-Bounded Random Replacement Index

This block produces the slot number used when a new entry is written into a 48-slot translation buffer at a pseudo-random position. A 6-bit counter steps down by one on every clock. It stays inside a window whose top is the last slot, 47, and whose bottom is a programmable floor held in a second register. Slots below the floor are reserved for pinned entries, so random replacement never selects them.

Software reaches both registers through a single-word register port. A select bit picks the counter or the floor. Writing the floor restarts the counter at the top slot. Writes aimed at the counter are dropped. The current slot number is also driven on a dedicated output, which the random-write command samples whenever it fires. The index output has no handshake: it is valid in every cycle once reset is released, and the consumer takes the value present in the cycle of its command. The register port is a plain single-cycle strobe with combinational read data, and it never stalls.

Top module: `rnd_repl_index`

## Requirements
- R1: While synchronous reset (`rst_n` low) is applied at a clock edge, the counter becomes 47 and the floor becomes 0.
- R2: With no floor write, a counter value greater than the floor decrements by exactly one at the next clock edge.
- R3: `repl_idx` never exceeds 47, and it is never below the floor unless it equals 47.
- R4: When the counter is at or below the floor, the next clock edge loads 47. With a floor of F below 47, the sequence is periodic with period 48-F.
- R5: A write with `cfg_sel`=1 stores `cfg_wdata[5:0]` as the floor, and the counter reads 47 after that clock edge. This holds even when the value written equals the current floor.
- R6: A write with `cfg_sel`=0 has no effect on the counter sequence or on the floor.
- R7: When the floor is 47 or higher (up to 63), the counter holds at 47.
- R8: `cfg_rdata` shows the counter when `cfg_sel`=0 and the floor when `cfg_sel`=1, in bits 5:0. Bits 31:6 read as zero, and the upper bits of the write data are discarded.
- R9: `repl_idx` always equals the counter value that is read back with `cfg_sel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe, one cycle per write |
| cfg_sel | input | 1 | Register select: 0 = counter (read-only), 1 = floor |
| cfg_wdata | input | 32 | Write data; only bits 5:0 are used |
| cfg_rdata | output | 32 | Read data of the selected register, zero-extended |
| repl_idx | output | 6 | Slot index for random replacement |

## Verification
The bench programs every floor value from 0 to 63 and follows each sequence for more than two full periods. This catches a counter that wraps one slot early or late, which would show up as a wrong period or a reserved slot being selected. It also catches a design that goes on decrementing when the floor sits at or above the top slot, instead of holding at 47. It rewrites the floor with the value it already holds, and a design that reloads only on a change would then keep counting instead of jumping to 47. It also writes to the counter in the middle of a sequence and with junk in the upper data bits. A design that let either write through would break the expected sequence or read back non-zero upper bits.

// File: rtl/rri_pkg.sv
package rri_pkg;
  typedef enum logic {
    SEL_COUNTER = 1'b0,
    SEL_FLOOR   = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/rri_floor_reg.sv
module rri_floor_reg #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_val,
  output logic [IDX_W-1:0] floor_q,
  output logic             reload
);
  always_ff @(posedge clk) begin
    if (!rst_n) floor_q <= '0;
    else if (wr_en) floor_q <= wr_val;
  end

  // Any floor write restarts the counter, whatever value is written.
  assign reload = wr_en;
endmodule

// File: rtl/rri_down_counter.sv
module rri_down_counter #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [IDX_W-1:0] floor_q,
  output logic [IDX_W-1:0] cnt_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt_d;
  logic             at_floor;

  // "At or below" also covers floors above the top slot: the counter holds.
  assign at_floor = (cnt_q <= floor_q);

  always_comb begin
    if (reload || at_floor) cnt_d = TOP;
    else                    cnt_d = cnt_q - IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= TOP;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rri_read_mux.sv
module rri_read_mux #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  rri_pkg::cfg_sel_e sel,
  input  logic [IDX_W-1:0]  cnt_q,
  input  logic [IDX_W-1:0]  floor_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (sel)
      rri_pkg::SEL_COUNTER: rdata[IDX_W-1:0] = cnt_q;
      rri_pkg::SEL_FLOOR:   rdata[IDX_W-1:0] = floor_q;
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/rnd_repl_index.sv
module rnd_repl_index #(
  parameter int ENTRIES = 48,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [$clog2(ENTRIES)-1:0] repl_idx
);
  localparam int IDX_W = $clog2(ENTRIES);

  rri_pkg::cfg_sel_e sel_e;
  logic              floor_wr;
  logic              reload;
  logic [IDX_W-1:0]  floor_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              unused_wdata_hi;

  assign sel_e           = rri_pkg::cfg_sel_e'(cfg_sel);
  assign floor_wr        = cfg_wr && (sel_e == rri_pkg::SEL_FLOOR);
  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:IDX_W];

  rri_floor_reg #(.IDX_W(IDX_W)) u_floor (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (floor_wr),
    .wr_val  (cfg_wdata[IDX_W-1:0]),
    .floor_q (floor_q),
    .reload  (reload)
  );

  rri_down_counter #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload),
    .floor_q (floor_q),
    .cnt_q   (cnt_q)
  );

  rri_read_mux #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
    .sel     (sel_e),
    .cnt_q   (cnt_q),
    .floor_q (floor_q),
    .rdata   (cfg_rdata)
  );

  assign repl_idx = cnt_q;
endmodule

// File: rtl/rri_checker.sv
module rri_checker #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_sel,
  input logic [IDX_W-1:0] repl_idx,
  input logic [IDX_W-1:0] floor_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  p_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_idx <= TOP) && ((repl_idx >= floor_q) || (repl_idx == TOP)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_wr && cfg_sel) && ($past(repl_idx) > $past(floor_q)))
    |-> (repl_idx == $past(repl_idx) - IDX_W'(1)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(repl_idx) <= $past(floor_q))) |-> (repl_idx == TOP));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_wr && cfg_sel)) |-> (repl_idx == TOP));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_wr && !cfg_sel)) |-> $stable(floor_q));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (floor_q >= TOP) && ($past(floor_q) >= TOP)) |-> (repl_idx == TOP));
endmodule

bind rnd_repl_index rri_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_sel  (cfg_sel),
  .repl_idx (repl_idx),
  .floor_q  (floor_q)
);

// File: tb/rnd_repl_index_bench.sv
`timescale 1ns/1ps
module rnd_repl_index_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [5:0]  repl_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rnd_repl_index u_rnd_repl_index (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .repl_idx(repl_idx)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected slot k cycles after a floor write of f (k starts at 1).
  function automatic int model(input int f, input int k);
    if (f >= 47) return 47;
    return 47 - ((k - 1) % (48 - f));
  endfunction

  task automatic write_reg(input logic sel, input logic [31:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic read_both(input string req, input int exp_cnt, input int exp_floor);
    cfg_sel = 1'b0; #0.1;
    check({req, " counter read"}, cfg_rdata, exp_cnt);
    check("R9 index matches counter read", repl_idx, cfg_rdata[5:0]);
    cfg_sel = 1'b1; #0.1;
    check({req, " floor read"}, cfg_rdata, exp_floor);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset index", repl_idx, 47);
    read_both("R1", 47, 0);
    rst_n = 1'b1;

    // R2 R4: free run from reset with floor 0, period 48
    for (int n = 1; n <= 100; n++) begin
      @(negedge clk);
      check("R2 R4 run from reset", repl_idx, 47 - (n % 48));
    end

    // R3 R4 R7 R8: every floor value, junk in upper data bits
    for (int f = 0; f < 64; f++) begin
      write_reg(1'b1, 32'hA5A5_A5C0 | f);
      check("R5 reload after floor write", repl_idx, 47);
      cfg_sel = 1'b1; #0.1;
      check("R8 floor read zero-extended", cfg_rdata, f);
      for (int k = 2; k <= 110; k++) begin
        @(negedge clk);
        check(f >= 47 ? "R7 hold at top" : "R3 R4 bounded sequence", repl_idx, model(f, k));
      end
    end

    // R5: rewrite same floor mid-sequence
    write_reg(1'b1, 32'd10);
    repeat (5) @(negedge clk);
    check("R5 pre-rewrite position", repl_idx, model(10, 6));
    write_reg(1'b1, 32'd10);
    check("R5 same-value rewrite reloads", repl_idx, 47);
    @(negedge clk);
    check("R5 continues after rewrite", repl_idx, 46);

    // R6: counter writes are ignored
    write_reg(1'b1, 32'd3);
    for (int k = 2; k <= 8; k++) @(negedge clk);
    check("R6 before counter write", repl_idx, model(3, 8));
    write_reg(1'b0, 32'hFFFF_FF11);
    check("R6 counter write ignored", repl_idx, model(3, 9));
    read_both("R6 R8", model(3, 9), 3);
    for (int k = 10; k <= 60; k++) begin
      @(negedge clk);
      check("R6 sequence undisturbed", repl_idx, model(3, k));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule